// File: doc/BRIEF.md
# Serial Port FIFO Pair with Receive Trigger

This block holds the transmit and receive byte queues of a 16550-style serial port. Each direction has a 16-entry first-in first-out store. A write-only control word sets the operating mode. Its fields are an enable bit, a transmit-clear bit, a receive-clear bit, a ready-signalling mode bit and a two-bit receive threshold. The serializer on one side and the bus logic on the other push and pop bytes through strobes. The block reports the fill level of each queue and the byte at the head of each queue.

The receive side raises an interrupt when its fill level equals the selected threshold, provided the interrupt enable is high. Two ready outputs pace an external DMA engine. Their meaning depends on the mode bit.

When the FIFOs are disabled, each direction holds at most one byte and behaves as a plain holding register. Toggling the enable bit flushes both queues. Each clear bit flushes only its own queue, and clear bits return to zero by themselves one cycle after the write.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both fill levels are 0, the control word is all zeros (FIFOs disabled, mode 0, threshold code 0), `rda_irq` and `rx_overrun` are 0, `tx_ready` is 1 and `rx_ready` is 0.
- R2: With the FIFOs enabled (control bit 0 = 1), the transmit queue returns bytes in push order and holds at most 16 of them. A push into a full queue without a pop in the same cycle is ignored.
- R3: A receive push into a full receive queue, with no pop in the same cycle, discards the byte and sets `rx_overrun`. `rx_overrun` stays set until the receive queue is flushed.
- R4: Writing 1 to control bit 2 empties the transmit queue at the clock edge after the write. The receive queue is left untouched.
- R5: Writing 1 to control bit 1 empties the receive queue at the clock edge after the write, and clears `rx_overrun`. The transmit queue is left untouched.
- R6: The clear bits last one cycle. A later write that keeps bit 0 unchanged and has bits 1 and 2 at 0 leaves both queues unchanged.
- R7: A write that changes bit 0 flushes both queues at the following edge. While bit 0 is 0, each queue holds at most one byte.
- R8: The threshold is set by bits 5:4. Code 0 selects 1 byte, code 1 selects 4, code 2 selects 8 and code 3 selects 14. While disabled, the threshold is 1. `rda_irq` is high exactly when `rda_ie` is high and the receive level equals the threshold.
- R9: In mode 0 (bit 3 = 0, or FIFOs disabled), `rx_ready` is high when the receive queue is non-empty. `tx_ready` is high when the transmit queue is empty.
- R10: In mode 1 (bit 3 = 1 and bit 0 = 1), `rx_ready` is high when the receive level is at or above the threshold. `tx_ready` is high when the transmit queue is not full. With bit 0 = 0, mode 0 applies regardless of bit 3.
- R11: A push and a pop in the same cycle on a full queue are both accepted, and the level is unchanged. A pop from an empty queue is ignored.
- R12: A flush takes priority over a push or pop in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: bit 0 enable, bit 1 receive clear, bit 2 transmit clear, bit 3 mode, bits 5:4 threshold |
| rda_ie | input | 1 | Receive-data interrupt enable |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop the transmit head |
| tx_head | output | 8 | Byte at the transmit head (valid when non-empty) |
| tx_level | output | 5 | Transmit fill level |
| rx_push | input | 1 | Push a received byte |
| rx_data | input | 8 | Received byte |
| rx_pop | input | 1 | Pop the receive head |
| rx_head | output | 8 | Byte at the receive head (valid when non-empty) |
| rx_level | output | 5 | Receive fill level |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rda_irq | output | 1 | Received-data-available interrupt |
| rx_ready | output | 1 | Receive ready for DMA pacing |
| tx_ready | output | 1 | Transmit ready for DMA pacing |

## Verification
The bench targets the following corner cases:
- **Threshold compare.** The bench steps the receive level one byte past each threshold. A design that compared with at-or-above instead of equality would keep `rda_irq` high there.
- **Full queue with push and pop together.** The bench pushes and pops in the same cycle on a full queue. A design that tested fullness before applying the pop would drop that byte.
- **Flush on the same edge as a push.** The bench pushes in the very cycle a flush lands. A design giving the push priority would leave one byte behind and show a level of 1.
- **Mode bit while disabled.** The bench sets the mode bit while the FIFOs are off. A design that ignored the enable would report transmit-ready with a byte pending.
- **Randomised traffic.** Long runs of mixed pushes, pops and control writes are compared cycle by cycle against a queue model. This exposes pointer wrap and one-deep holding errors.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int CTL_W      = 6;
  localparam int CTL_EN     = 0;
  localparam int CTL_RXCLR  = 1;
  localparam int CTL_TXCLR  = 2;
  localparam int CTL_DMA    = 3;
  localparam int CTL_TRG_LO = 4;

  typedef struct packed {
    logic       en;
    logic       dma;
    logic [1:0] trig;
  } fifo_ctl_t;

  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo_ctl_reg.sv
module uart_fifo_ctl_reg
  import uart_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output fifo_ctl_t        ctl,
  output logic             tx_flush,
  output logic             rx_flush
);

  fifo_ctl_t ctl_q, ctl_nxt;
  logic      txf_q, txf_nxt;
  logic      rxf_q, rxf_nxt;
  logic      en_change;

  always_comb begin
    ctl_nxt   = ctl_q;
    txf_nxt   = 1'b0;
    rxf_nxt   = 1'b0;
    en_change = 1'b0;
    if (we) begin
      en_change    = wdata[CTL_EN] != ctl_q.en;
      ctl_nxt.en   = wdata[CTL_EN];
      ctl_nxt.dma  = wdata[CTL_DMA];
      ctl_nxt.trig = wdata[CTL_TRG_LO +: 2];
      txf_nxt      = wdata[CTL_TXCLR] | en_change;
      rxf_nxt      = wdata[CTL_RXCLR] | en_change;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      txf_q <= 1'b0;
      rxf_q <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      txf_q <= txf_nxt;
      rxf_q <= rxf_nxt;
    end
  end

  assign ctl      = ctl_q;
  assign tx_flush = txf_q;
  assign rx_flush = rxf_q;

  // R6
  tx_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_q && !we) |=> !txf_q);
  // R6
  rx_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_q && !we) |=> !rxf_q);

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_nxt, rd_q, rd_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [CW-1:0] cap;
  logic          full, empty, do_push, do_pop, wr_en;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign full    = cnt_q >= cap;
  assign empty   = cnt_q == '0;
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign wr_en   = do_push & ~flush;
  assign drop    = push & ~do_push & ~flush;

  always_comb begin
    wr_nxt  = wr_q;
    rd_nxt  = rd_q;
    cnt_nxt = cnt_q;
    if (flush) begin
      wr_nxt  = '0;
      rd_nxt  = '0;
      cnt_nxt = '0;
    end else begin
      if (do_push) wr_nxt = bump(wr_q);
      if (do_pop)  rd_nxt = bump(rd_q);
      cnt_nxt = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R12
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  // R11
  pop_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  fifo_ctl_t     ctl,
  input  logic          rda_ie,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rda_irq,
  output logic          rx_ready,
  output logic          tx_ready
);

  logic [CW-1:0] level;
  logic          mode1;

  always_comb begin
    level    = ctl.en ? CW'(trig_level(ctl.trig)) : CW'(1);
    mode1    = ctl.dma & ctl.en;
    rda_irq  = rda_ie & (rx_count == level);
    rx_ready = mode1 ? (rx_count >= level)       : (rx_count != '0);
    tx_ready = mode1 ? (tx_count < CW'(DEPTH))   : (tx_count == '0);
  end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             rda_ie,
  input  logic             tx_push,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_pop,
  output logic [W-1:0]     tx_head,
  output logic [CW-1:0]    tx_level,
  input  logic             rx_push,
  input  logic [W-1:0]     rx_data,
  input  logic             rx_pop,
  output logic [W-1:0]     rx_head,
  output logic [CW-1:0]    rx_level,
  output logic             rx_overrun,
  output logic             rda_irq,
  output logic             rx_ready,
  output logic             tx_ready
);

  fifo_ctl_t ctl;
  logic      tx_flush, rx_flush, tx_drop, rx_drop;
  logic      ovr_q, ovr_nxt;

  uart_fifo_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl(ctl), .tx_flush(tx_flush), .rx_flush(rx_flush)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(~ctl.en),
    .push(tx_push), .din(tx_data), .pop(tx_pop),
    .dout(tx_head), .count(tx_level), .drop(tx_drop)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(~ctl.en),
    .push(rx_push), .din(rx_data), .pop(rx_pop),
    .dout(rx_head), .count(rx_level), .drop(rx_drop)
  );

  uart_fifo_status #(.DEPTH(DEPTH)) u_stat (
    .ctl(ctl), .rda_ie(rda_ie), .rx_count(rx_level), .tx_count(tx_level),
    .rda_irq(rda_irq), .rx_ready(rx_ready), .tx_ready(tx_ready)
  );

  always_comb begin
    ovr_nxt = ovr_q;
    if (rx_flush)     ovr_nxt = 1'b0;
    else if (rx_drop) ovr_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_nxt;
  end

  assign rx_overrun = ovr_q;

  // R3
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_overrun);
  // R2
  tx_drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> $stable(tx_level));
  // R8
  irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rda_irq |-> (rx_level != '0));
  // R5
  overrun_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_overrun);

endmodule

// File: tb/uart_fifo_ctl_bench.sv
module uart_fifo_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic       rda_ie = 1'b0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_data = '0, rx_data = '0;
  logic [7:0] tx_head, rx_head;
  logic [4:0] tx_level, rx_level;
  logic       rx_overrun, rda_irq, rx_ready, tx_ready;

  int checks = 0;
  int errors = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctl u_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rda_ie(rda_ie), .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop),
    .tx_head(tx_head), .tx_level(tx_level), .rx_push(rx_push),
    .rx_data(rx_data), .rx_pop(rx_pop), .rx_head(rx_head),
    .rx_level(rx_level), .rx_overrun(rx_overrun), .rda_irq(rda_irq),
    .rx_ready(rx_ready), .tx_ready(tx_ready)
  );

  // reference model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit m_en, m_dma, m_txf, m_rxf, m_ovr;
  logic [1:0] m_trig;

  function automatic int lvl(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
  endfunction

  always @(posedge clk) begin : model
    int cap;
    bit tpo, tpu, rpo, rpu;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_en = 0; m_dma = 0; m_txf = 0; m_rxf = 0; m_ovr = 0; m_trig = 0;
    end else begin
      cap = m_en ? DEPTH : 1;
      if (m_txf) txq.delete();
      else begin
        tpo = tx_pop && txq.size() > 0;
        tpu = tx_push && (txq.size() < cap || tpo);
        if (tpo) void'(txq.pop_front());
        if (tpu) txq.push_back(tx_data);
      end
      if (m_rxf) begin
        rxq.delete(); m_ovr = 0;
      end else begin
        rpo = rx_pop && rxq.size() > 0;
        rpu = rx_push && (rxq.size() < cap || rpo);
        if (rpo) void'(rxq.pop_front());
        if (rpu) rxq.push_back(rx_data);
        if (rx_push && !rpu) m_ovr = 1;
      end
      m_txf = 0; m_rxf = 0;
      if (ctl_we) begin
        m_txf = ctl_wdata[2] || (ctl_wdata[0] != m_en);
        m_rxf = ctl_wdata[1] || (ctl_wdata[0] != m_en);
        m_en = ctl_wdata[0]; m_dma = ctl_wdata[3]; m_trig = ctl_wdata[5:4];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin : cmp
    int th;
    bit m1;
    if (live && rst_n) begin
      th = m_en ? lvl(m_trig) : 1;
      m1 = m_dma && m_en;
      chk(tx_level == txq.size(), "R2 tx level", tx_level, txq.size());
      if (txq.size() > 0) chk(tx_head == txq[0], "R2 tx head", tx_head, txq[0]);
      chk(rx_level == rxq.size(), "R3 rx level", rx_level, rxq.size());
      if (rxq.size() > 0) chk(rx_head == rxq[0], "R3 rx head", rx_head, rxq[0]);
      chk(rx_overrun == m_ovr, "R3 overrun", rx_overrun, m_ovr);
      chk(rda_irq == (rda_ie && rxq.size() == th), "R8 irq", rda_irq,
          rda_ie && rxq.size() == th);
      chk(rx_ready == (m1 ? rxq.size() >= th : rxq.size() != 0), "R9 rx_ready",
          rx_ready, m1 ? rxq.size() >= th : rxq.size() != 0);
      chk(tx_ready == (m1 ? txq.size() < DEPTH : txq.size() == 0), "R10 tx_ready",
          tx_ready, m1 ? txq.size() < DEPTH : txq.size() == 0);
    end
  end

  task automatic cyc(input bit we, input logic [5:0] wd, input bit tpu,
                     input logic [7:0] td, input bit tpo, input bit rpu,
                     input logic [7:0] rd, input bit rpo);
    ctl_we = we; ctl_wdata = wd; tx_push = tpu; tx_data = td; tx_pop = tpo;
    rx_push = rpu; rx_data = rd; rx_pop = rpo;
    @(posedge clk); #1;
    ctl_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic idle(); cyc(0, '0, 0, '0, 0, 0, '0, 0); endtask
  task automatic at_neg(); @(negedge clk); endtask
  task automatic resume(); @(posedge clk); #1; endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;
    // R1 reset state
    at_neg();
    chk(tx_level == 0 && rx_level == 0, "R1 levels", tx_level + rx_level, 0);
    chk(!rda_irq && !rx_overrun, "R1 irq/overrun", rda_irq + rx_overrun, 0);
    chk(tx_ready && !rx_ready, "R1 ready", {tx_ready, rx_ready}, 2);
    resume();
    // R7 disabled: one-byte holding
    cyc(0, '0, 1, 8'hA1, 0, 1, 8'h11, 0);
    cyc(0, '0, 1, 8'hB2, 0, 1, 8'h22, 0);
    at_neg();
    chk(tx_level == 1 && tx_head == 8'hA1, "R7 tx single", tx_level, 1);
    chk(rx_level == 1 && rx_overrun, "R7 rx single", rx_level, 1);
    resume();
    // R7 enabling flushes both
    cyc(1, 6'h01, 0, '0, 0, 0, '0, 0);
    idle();
    at_neg();
    chk(tx_level == 0 && rx_level == 0 && !rx_overrun, "R7 enable flush",
        tx_level + rx_level, 0);
    resume();
    // R2 fill past depth
    for (int i = 0; i < 20; i++) cyc(0, '0, 1, 8'(i), 0, 0, '0, 0);
    at_neg();
    chk(tx_level == 16 && tx_head == 0, "R2 full cap", tx_level, 16);
    resume();
    // R11 push+pop at full
    cyc(0, '0, 1, 8'h55, 1, 0, '0, 0);
    at_neg();
    chk(tx_level == 16 && tx_head == 1, "R11 push pop full", tx_level, 16);
    resume();
    // R4 tx flush leaves rx
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, '0, 0, 1, 8'(8'h30 + i), 0);
    cyc(1, 6'h05, 0, '0, 0, 0, '0, 0);
    idle();
    at_neg();
    chk(tx_level == 0 && rx_level == 3, "R4 tx flush", {tx_level, rx_level}, 3);
    resume();
    // R6 write without clear bits
    cyc(1, 6'h01, 0, '0, 0, 0, '0, 0);
    idle(); idle();
    at_neg();
    chk(rx_level == 3, "R6 no-op write", rx_level, 3);
    resume();
    // R5 rx flush leaves tx
    cyc(0, '0, 1, 8'h77, 0, 0, '0, 0);
    cyc(1, 6'h03, 0, '0, 0, 0, '0, 0);
    idle();
    at_neg();
    chk(rx_level == 0 && tx_level == 1, "R5 rx flush", {rx_level, tx_level}, 1);
    resume();
    // R11 pop from empty
    cyc(0, '0, 0, '0, 0, 0, '0, 1);
    at_neg();
    chk(rx_level == 0, "R11 pop empty", rx_level, 0);
    resume();
    // R8 threshold 4, equality
    rda_ie = 1;
    cyc(1, 6'h11, 0, '0, 0, 0, '0, 0);
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, '0, 0, 1, 8'(8'h40 + i), 0);
    at_neg();
    chk(rda_irq == 1, "R8 irq at 4", rda_irq, 1);
    resume();
    cyc(0, '0, 0, '0, 0, 1, 8'h44, 0);
    at_neg();
    chk(rda_irq == 0, "R8 irq above", rda_irq, 0);
    resume();
    // R9 mode 0 then R10 mode 1
    at_neg();
    chk(rx_ready == 1 && tx_ready == 0, "R9 mode0", {rx_ready, tx_ready}, 2);
    resume();
    cyc(1, 6'h39, 0, '0, 0, 0, '0, 0);
    at_neg();
    chk(rx_ready == 0 && tx_ready == 1, "R10 mode1 trig14", {rx_ready, tx_ready}, 1);
    resume();
    // R3 overrun in FIFO mode
    for (int i = 0; i < 14; i++) cyc(0, '0, 0, '0, 0, 1, 8'(8'h60 + i), 0);
    at_neg();
    chk(rx_level == 16 && rx_overrun, "R3 overrun", rx_level, 16);
    resume();
    // R12 flush beats push
    cyc(1, 6'h1B, 0, '0, 0, 1, 8'h99, 0);
    cyc(0, '0, 0, '0, 0, 1, 8'h9A, 0);
    at_neg();
    chk(rx_level == 0 && !rx_overrun, "R12 flush wins", rx_level, 0);
    resume();
    // R10 mode bit ignored while disabled
    cyc(1, 6'h08, 0, '0, 0, 0, '0, 0);
    idle();
    cyc(0, '0, 1, 8'h5A, 0, 0, '0, 0);
    at_neg();
    chk(tx_level == 1 && tx_ready == 0, "R10 disabled mode0", tx_ready, 0);
    resume();
    // randomised traffic
    for (int i = 0; i < 3000; i++) begin
      rda_ie = ($urandom_range(0, 7) != 0);
      cyc(($urandom_range(0, 40) == 0), 6'($urandom_range(0, 63)),
          $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 2) == 0,
          $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 2) == 0);
    end
    idle();
    finish_up();
  end

endmodule